// File: doc/BRIEF.md
# Addressable-LED Line Encoder

This block converts a stream of colour bytes into the single-wire pulse train that daisy-chained addressable RGB LEDs decode. Every data bit becomes a short, fixed group of line samples. One sample is emitted per sample-enable tick, and the tick is meant to run at about 3 MHz, which gives roughly 333 ns per sample. Bytes are taken through a valid/ready handshake, and the final byte of a frame is flagged with `in_last`. Each byte is split into its upper and lower nibble, and each nibble is turned into a code word that a sample shifter then plays out.

A two-bit mode input chooses one of three pulse codes: a three-sample code, a four-sample code, or a four-sample code with a shorter high time for '1' that suits a second LED family. The mode is captured when the first byte of a frame is accepted and is held until the frame is finished. After the last byte, the block pads the frame with low samples up to a whole number of `PAD_BYTES` byte slots. It then keeps the line low for `LATCH_SAMPLES` further ticks so the LEDs latch. Only after that does it accept a new frame.

Top module: `led_line_encoder`

## Requirements
- R1: After reset `line_out` is low and `in_ready` is high.
- R2: Mode 2'b00 (three-sample) sends a 0 bit as the samples 1,0,0 and a 1 bit as 1,1,0.
- R3: Mode 2'b01 (four-sample) sends a 0 bit as 1,0,0,0 and a 1 bit as 1,1,1,0.
- R4: Mode 2'b10 (short-high four-sample) sends a 0 bit as 1,0,0,0 and a 1 bit as 1,1,0,0.
- R5: Within a byte the bits go out most significant first, so the upper nibble precedes the lower one, and consecutive bytes follow with no gap when supplied in time.
- R6: After the last byte, each byte slot missing up to the next multiple of `PAD_BYTES` (a multiple of 4) is sent as 8 × samples-per-bit low samples, not as coded 0 bits.
- R7: After the padding the line stays low for exactly `LATCH_SAMPLES` ticks; `in_ready` rises on the last of those ticks and not before.
- R8: `in_mode` is sampled only when a frame's first byte is accepted; changing it mid-frame has no effect on that frame.
- R9: Mode 2'b11 behaves exactly like mode 2'b01.
- R10: Once a byte with `in_last` high has been accepted, `in_ready` stays low until the latch gap ends.
- R11: `line_out` changes only in cycles where `smp_en` is high; with no ticks it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample tick, one line sample per high cycle |
| in_mode | input | 2 | Pulse-code select, sampled at frame start |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Colour byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| line_out | output | 1 | Serial LED line |

## Verification
The bench builds the encoder with `PAD_BYTES` = 4 and `LATCH_SAMPLES` = 12. With these values every padding length from zero to three byte slots, as well as the exact latch-gap count, appears in frames of one to five bytes. It also makes back-to-back frames cheap enough to run in every mode, including a mid-frame mode change and a stretch with ticks withheld. The default values differ only in counter width and count limits, not in control structure.

// File: rtl/led_line_pkg.sv
package led_line_pkg;

    typedef enum logic [1:0] {
        ENC_TRI        = 2'b00,
        ENC_QUAD       = 2'b01,
        ENC_QUAD_SHORT = 2'b10,
        ENC_QUAD_ALT   = 2'b11
    } enc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DATA = 2'b01,
        ST_TAIL = 2'b10
    } frame_state_e;

    localparam int NIB_BITS = 4;
    localparam int MAX_SPB  = 4;
    localparam int CODE_W   = NIB_BITS * MAX_SPB;
    localparam int LEN_W    = $clog2(CODE_W + 1);

endpackage

// File: rtl/led_nib_coder.sv
module led_nib_coder
    import led_line_pkg::*;
(
    input  enc_mode_e               mode_i,
    input  logic [NIB_BITS-1:0]     nib_i,
    output logic [CODE_W-1:0]       code_o,
    output logic [LEN_W-1:0]        len_o
);

    // Left-aligned code word; the first sample to send sits in the MSB.
    always_comb begin
        code_o = '0;
        len_o  = (mode_i == ENC_TRI) ? LEN_W'(NIB_BITS * 3) : LEN_W'(NIB_BITS * 4);
        for (int i = 0; i < NIB_BITS; i++) begin
            logic bv;
            bv = nib_i[NIB_BITS-1-i];
            case (mode_i)
                ENC_TRI:        code_o[CODE_W-1-3*i -: 3] = {1'b1, bv, 1'b0};
                ENC_QUAD_SHORT: code_o[CODE_W-1-4*i -: 4] = {1'b1, bv, 2'b00};
                default:        code_o[CODE_W-1-4*i -: 4] = {1'b1, bv, bv, 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/led_smp_shifter.sv
module led_smp_shifter
    import led_line_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                load_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic                smp_o,
    output logic [LEN_W-1:0]    rem_o
);

    typedef struct packed {
        logic [CODE_W-1:0] sr;
        logic [LEN_W-1:0]  rem;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d     = q;
        smp_o = 1'b0;
        if (tick_i) begin
            if (load_i) begin
                smp_o = code_i[CODE_W-1];
                d.sr  = code_i << 1;
                d.rem = len_i - LEN_W'(1);
            end else if (q.rem != '0) begin
                smp_o = q.sr[CODE_W-1];
                d.sr  = q.sr << 1;
                d.rem = q.rem - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rem_o = q.rem;

    // A new code word is only taken once the previous one has fully played out.
    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (q.rem == '0)); // R5

    // A load always comes with a tick.
    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> tick_i); // R11

endmodule

// File: rtl/led_line_encoder.sv
module led_line_encoder
    import led_line_pkg::*;
#(
    parameter int PAD_BYTES     = 32,
    parameter int LATCH_SAMPLES = 150
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_en,
    input  logic [1:0]  in_mode,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        line_out
);

    localparam int BYTE_BITS = 8;
    localparam int ZERO_MAX  = (PAD_BYTES - 1) * BYTE_BITS * MAX_SPB + LATCH_SAMPLES;
    localparam int ZW        = $clog2(ZERO_MAX + 1);
    localparam int BW        = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;

    typedef struct packed {
        frame_state_e           state;
        enc_mode_e              mode;
        logic [BYTE_BITS-1:0]   hold;
        logic                   hold_v;
        logic                   hold_last;
        logic [NIB_BITS-1:0]    lo;
        logic                   lo_v;
        logic                   lo_last;
        logic                   tail_arm;
        logic                   stop;
        logic [BW-1:0]          bcnt;
        logic [ZW-1:0]          zeros;
        logic                   line;
    } ctl_t;

    ctl_t d, q;

    logic                load;
    logic                smp;
    logic [LEN_W-1:0]    rem;
    logic [CODE_W-1:0]   code;
    logic [LEN_W-1:0]    code_len;
    logic [NIB_BITS-1:0] nib_sel;
    logic                ready;
    logic [ZW-1:0]       tail_len;

    assign nib_sel = q.lo_v ? q.lo : q.hold[BYTE_BITS-1 -: NIB_BITS];

    led_nib_coder u_coder (
        .mode_i (q.mode),
        .nib_i  (nib_sel),
        .code_o (code),
        .len_o  (code_len)
    );

    led_smp_shifter u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (smp_en),
        .load_i (load),
        .code_i (code),
        .len_i  (code_len),
        .smp_o  (smp),
        .rem_o  (rem)
    );

    always_comb begin
        int pad_b;
        int spb_i;
        d        = q;
        load     = 1'b0;
        pad_b    = (q.bcnt == '0) ? 0 : PAD_BYTES - int'(q.bcnt);
        spb_i    = (q.mode == ENC_TRI) ? 3 : 4;
        tail_len = ZW'(pad_b * spb_i * BYTE_BITS + LATCH_SAMPLES);
        ready    = (q.state == ST_IDLE) ||
                   ((q.state == ST_DATA) && !q.hold_v && !q.stop);

        case (q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    d.state     = ST_DATA;
                    d.mode      = enc_mode_e'(in_mode);
                    d.hold      = in_data;
                    d.hold_v    = 1'b1;
                    d.hold_last = in_last;
                    d.stop      = in_last;
                    d.lo_v      = 1'b0;
                    d.tail_arm  = 1'b0;
                    d.bcnt      = '0;
                end
            end
            ST_DATA: begin
                if (in_valid && ready) begin
                    d.hold      = in_data;
                    d.hold_v    = 1'b1;
                    d.hold_last = in_last;
                    d.stop      = in_last;
                end
                if (smp_en) begin
                    if (rem == '0) begin
                        if (q.lo_v) begin
                            load       = 1'b1;
                            d.lo_v     = 1'b0;
                            d.tail_arm = q.lo_last;
                        end else if (q.hold_v) begin
                            load      = 1'b1;
                            d.hold_v  = 1'b0;
                            d.lo      = q.hold[NIB_BITS-1:0];
                            d.lo_v    = 1'b1;
                            d.lo_last = q.hold_last;
                            d.bcnt    = (q.bcnt == BW'(PAD_BYTES - 1)) ? '0 : q.bcnt + BW'(1);
                        end
                    end else if (q.tail_arm && (rem == LEN_W'(1))) begin
                        d.state    = ST_TAIL;
                        d.zeros    = tail_len;
                        d.tail_arm = 1'b0;
                    end
                end
            end
            ST_TAIL: begin
                if (smp_en) begin
                    d.zeros = q.zeros - ZW'(1);
                    if (q.zeros == ZW'(1)) begin
                        d.state = ST_IDLE;
                        d.stop  = 1'b0;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (smp_en) begin
            d.line = smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready = ready;
    assign line_out = q.line;

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !line_out); // R7

    AST_TAIL_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_TAIL) |-> !line_out); // R6

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(line_out)); // R11

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |=> $stable(q.mode)); // R8

    AST_NO_ACCEPT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready); // R10

endmodule

// File: tb/led_line_encoder_tb.sv
module led_line_encoder_tb;

    localparam int PAD   = 4;
    localparam int LATCH = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic [1:0] in_mode = 2'b00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       line_out;

    always #4 clk = ~clk;

    led_line_encoder #(.PAD_BYTES(PAD), .LATCH_SAMPLES(LATCH)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .in_mode  (in_mode),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .line_out (line_out)
    );

    typedef struct {
        bit    v;
        string r;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] fb[$];
    int  n_chk = 0;
    int  n_fail = 0;
    int  tdiv = 0;
    bit  pause = 0;
    bit  aligned = 0;
    bit  gap_active = 0;
    int  gapcnt = 0;
    bit  last_line = 0;
    bit  done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_s(input bit v, input string r);
        exp_t e;
        e.v = v;
        e.r = r;
        exp_q.push_back(e);
    endtask

    // Monitor and tick generator: sample away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (smp_en) begin
                last_line = line_out;
                if (!aligned && exp_q.size() > 0 && line_out) aligned = 1;
                if (aligned) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(line_out == e.v, e.r, "line sample", int'(line_out), int'(e.v));
                    if (exp_q.size() == 0) begin
                        aligned = 0;
                        gap_active = 1;
                        gapcnt = 0;
                    end
                end else if (gap_active) begin
                    gapcnt++;
                    chk(line_out == 1'b0, "R7", "latch gap line", int'(line_out), 0);
                    if (in_ready) begin
                        chk(gapcnt == LATCH, "R7", "latch gap length", gapcnt, LATCH);
                        gap_active = 0;
                    end else if (gapcnt > LATCH) begin
                        chk(0, "R7", "ready never rose, gap", gapcnt, LATCH);
                        gap_active = 0;
                    end
                end
            end else begin
                chk(line_out == last_line, "R11", "line held without tick", int'(line_out), int'(last_line));
            end
        end
        if (pause) begin
            smp_en = 1'b0;
        end else begin
            tdiv = (tdiv + 1) % 4;
            smp_en = (tdiv == 0);
        end
    end

    // Driver: queue expected samples for the frame in fb, then hand the bytes over.
    task automatic send_frame(input int mode, input int mode_late, input string req);
        int spb;
        int nb;
        int padn;
        while (exp_q.size() != 0 || gap_active || aligned) @(negedge clk);
        spb = (mode == 0) ? 3 : 4;
        foreach (fb[i]) begin
            for (int k = 7; k >= 0; k--) begin
                bit b;
                b = fb[i][k];
                push_s(1'b1, req);
                push_s(b, req);
                if (spb == 3) begin
                    push_s(1'b0, req);
                end else if (mode == 2) begin
                    push_s(1'b0, req);
                    push_s(1'b0, req);
                end else begin
                    push_s(b, req);
                    push_s(1'b0, req);
                end
            end
        end
        nb = fb.size() % PAD;
        padn = (nb == 0) ? 0 : PAD - nb;
        for (int s = 0; s < padn * 8 * spb; s++) push_s(1'b0, "R6");
        for (int i = 0; i < fb.size(); i++) begin
            @(negedge clk);
            in_mode  = (i == 0) ? 2'(mode) : 2'(mode_late);
            in_valid = 1'b1;
            in_data  = fb[i];
            in_last  = (i == fb.size() - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (20) @(negedge clk);
        chk(in_ready == 1'b0, "R10", "ready after last byte", int'(in_ready), 0);
        while (exp_q.size() != 0 || gap_active || aligned) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R1..watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_out == 1'b0, "R1", "line after reset", int'(line_out), 0);
        chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

        // R2 and R5: full group, no padding, MSB first
        fb = {8'hA5, 8'h3C, 8'hFF, 8'h00};
        send_frame(0, 0, "R2 R5");
        // R6: single byte, three padded slots
        fb = {8'h81};
        send_frame(0, 0, "R2 R6");
        // R3: two bytes, two padded slots
        fb = {8'h5A, 8'hC3};
        send_frame(1, 1, "R3");
        // R4: five bytes, wraps a pad block
        fb = {8'hF0, 8'h0F, 8'h96, 8'h69, 8'h01};
        send_frame(2, 2, "R4");
        // R9: mode 3 equals mode 1
        fb = {8'hE7};
        send_frame(3, 3, "R9");
        // R8: mode switched after first byte, frame stays three-sample
        fb = {8'hC9, 8'h36};
        send_frame(0, 2, "R8");
        // R11: ticks withheld mid-frame
        fb = {8'hAA, 8'h55, 8'h12};
        fork
            send_frame(1, 1, "R11 R3");
            begin
                repeat (150) @(negedge clk);
                pause = 1;
                repeat (40) @(negedge clk);
                pause = 0;
            end
        join

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule